// File: doc/BRIEF.md
# Pattern Fill DMA Engine

This block is a single-channel DMA engine whose one job is to fill a destination memory region with a repeating 64-bit pattern. It never reads. Software supplies the pattern as two 32-bit halves, together with a destination address, a destination address-space code, a transfer width, a byte count and an operation code. It then pulses `go_i`. The engine captures these values, validates them, and either latches error bits or issues a stream of write requests on a 32-bit request/grant bus with byte enables. When the last write is granted it pulses `done_o`.

The engine has four states. IDLE waits for `go_i` and captures the configuration (IDLE to CHECK). CHECK evaluates the configuration for one cycle. If any error bit is raised, CHECK goes back to IDLE. Otherwise CHECK goes to WRITE. WRITE holds a request until it is granted, then advances the address and the count. The grant of the final write moves WRITE to FINISH. FINISH raises `done_o` for one cycle and always returns to IDLE.

Each 32-bit word carries one half of the pattern. Destination address bit 2 selects the half: when it is 0 the word carries `pat_lo_i`, and when it is 1 the word carries `pat_hi_i`. Every aligned 64-bit word of the region therefore holds the complete pattern.

Top module: `fill_dma`

## Requirements
- R1: After reset, `req_o`, `busy_o` and `done_o` are 0, and `err_o`, `addr_o`, `wdata_o` and `be_o` are all zero.
- R2: Only opcode 0x4 (fill) is executed. Any other opcode sets `err_o[0]`, and that run issues no write request. This includes 0x0 to 0x3, which belong to copy and hash operations this engine does not serve.
- R3: The destination space code must be 0x7 (internal), 0xA (control) or 0x9 (system). Any other value sets `err_o[1]`.
- R4: Width code 1 (2 bytes) with destination bit 0 set sets `err_o[2]`. Width code 2 (4 bytes) with destination bits [1:0] not both zero also sets `err_o[2]`.
- R5: For space 0x7 or 0xA, any nonzero bit in destination address bits [63:32] sets `err_o[2]`. Space 0x9 accepts any upper bits.
- R6: Each of these sets `err_o[3]`: a size of 0, the reserved width code 3, or a size that is not a multiple of the width in bytes. Width code 0 means 1 byte.
- R7: The pattern halves are never checked. Any pattern value, including odd low bits or nonzero high bits, raises no error.
- R8: When the check passes, `req_o` is high in the second cycle after the cycle that sampled `go_i`. The run is made of writes only.
- R9: The write address is the current destination address with bits [1:0] cleared. `wdata_o` is `pat_lo_i` when the current address bit 2 is 0, and `pat_hi_i` when it is 1.
- R10: The byte enables are 0001 (1-byte width), 0011 (2-byte width) or 1111 (4-byte width), shifted left by address bits [1:0]. Lane k carries pattern byte k.
- R11: A request and its address, data and enables hold steady until granted. Each grant advances the address by the width in bytes, and a run makes exactly size/width writes.
- R12: `done_o` is a one-cycle pulse one cycle after the final grant. `busy_o` falls on the following cycle.
- R13: Error bits accumulate and stay set until `err_clr_i` is pulsed. A `go_i` that arrives while `busy_o` is high is ignored.
- R14: `addr_o`, `wdata_o` and `be_o` are zero whenever `req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start pulse, sampled only in IDLE |
| err_clr_i | input | 1 | Clears the latched error bits |
| opcode_i | input | 4 | Operation code (0x4 = fill) |
| space_i | input | 4 | Destination address-space code |
| width_i | input | 2 | Transfer width code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| dst_addr_i | input | 64 | Destination start byte address |
| size_i | input | 32 | Total number of bytes to fill |
| pat_lo_i | input | 32 | Pattern half written where address bit 2 is 0 |
| pat_hi_i | input | 32 | Pattern half written where address bit 2 is 1 |
| req_o | output | 1 | Write request |
| gnt_i | input | 1 | Write grant |
| addr_o | output | 64 | Word-aligned write address |
| wdata_o | output | 32 | Write data |
| be_o | output | 4 | Byte enables |
| busy_o | output | 1 | High outside IDLE |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 4 | Latched errors: [0] opcode, [1] space, [2] destination address, [3] size/width |

## Verification
A counter or half-select fault shows up at the very next granted write, as a wrong address, wrong pattern half or wrong enable pattern. It also shows up at the end of the run, where the number of writes is wrong or the `done_o` pulse comes early or late. A check that wrongly passes or wrongly fails shows within two cycles of `go_i`: either an error bit appears, or a request appears where none should. Stalled grants expose a request that moves before it is accepted. A missing busy guard shows as a changed or extra run when `go_i` is pulsed during a stall.

// File: rtl/fill_dma_pkg.sv
package fill_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } fsm_e;

    localparam logic [3:0] OP_FILL   = 4'h4;

    localparam logic [3:0] SPACE_INT = 4'h7;
    localparam logic [3:0] SPACE_CTL = 4'hA;
    localparam logic [3:0] SPACE_SYS = 4'h9;

    localparam logic [1:0] W_BYTE = 2'd0;
    localparam logic [1:0] W_HALF = 2'd1;
    localparam logic [1:0] W_WORD = 2'd2;
    localparam logic [1:0] W_RSVD = 2'd3;

    localparam int ERR_W     = 4;
    localparam int ERR_OP    = 0;
    localparam int ERR_SPACE = 1;
    localparam int ERR_DST   = 2;
    localparam int ERR_SIZE  = 3;

endpackage

// File: rtl/fill_dma_cfg_check.sv
module fill_dma_cfg_check
    import fill_dma_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int SIZE_W   = 32,
    parameter int NARROW_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [3:0]        space_i,
    input  logic [1:0]        width_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [ERR_W-1:0]  err_o
);

    logic upper_nz;

    // Upper-bit check exists only when the address is wider than a narrow space
    if (ADDR_W > NARROW_W) begin : g_wide
        assign upper_nz = |dst_i[ADDR_W-1:NARROW_W];
    end else begin : g_narrow
        assign upper_nz = 1'b0;
    end

    logic narrow_space;
    assign narrow_space = (space_i == SPACE_INT) || (space_i == SPACE_CTL);

    always_comb begin
        err_o = '0;

        if (op_i != OP_FILL) begin
            err_o[ERR_OP] = 1'b1;
        end

        if (!(space_i inside {SPACE_INT, SPACE_CTL, SPACE_SYS})) begin
            err_o[ERR_SPACE] = 1'b1;
        end

        if (width_i == W_HALF && dst_i[0]) begin
            err_o[ERR_DST] = 1'b1;
        end
        if (width_i == W_WORD && (|dst_i[1:0])) begin
            err_o[ERR_DST] = 1'b1;
        end
        if (narrow_space && upper_nz) begin
            err_o[ERR_DST] = 1'b1;
        end

        if (width_i == W_RSVD || size_i == '0) begin
            err_o[ERR_SIZE] = 1'b1;
        end else if (width_i == W_HALF && size_i[0]) begin
            err_o[ERR_SIZE] = 1'b1;
        end else if (width_i == W_WORD && (|size_i[1:0])) begin
            err_o[ERR_SIZE] = 1'b1;
        end
    end

endmodule

// File: rtl/fill_dma_lane_gen.sv
module fill_dma_lane_gen
    import fill_dma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8,
    localparam int OFF_W  = $clog2(STRB_W),
    localparam int STEP_W = OFF_W + 1
) (
    input  logic              active_i,
    input  logic [1:0]        width_i,
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [DATA_W-1:0] pat_lo_i,
    input  logic [DATA_W-1:0] pat_hi_i,
    output logic [STEP_W-1:0] step_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [STRB_W-1:0] be_o
);

    logic [STRB_W-1:0] base_mask;
    logic [STRB_W-1:0] shifted_mask;
    logic [DATA_W-1:0] half_sel;

    always_comb begin
        unique case (width_i)
            W_BYTE: begin
                base_mask = STRB_W'(1);
                step_o    = STEP_W'(1);
            end
            W_HALF: begin
                base_mask = STRB_W'(3);
                step_o    = STEP_W'(2);
            end
            default: begin
                base_mask = '1;
                step_o    = STEP_W'(STRB_W);
            end
        endcase
    end

    assign shifted_mask = base_mask << cur_i[OFF_W-1:0];
    // Address bit just above the lane offset picks the pattern half
    assign half_sel     = cur_i[OFF_W] ? pat_hi_i : pat_lo_i;

    always_comb begin
        if (active_i) begin
            addr_o  = {cur_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            wdata_o = half_sel;
            be_o    = shifted_mask;
        end else begin
            addr_o  = '0;
            wdata_o = '0;
            be_o    = '0;
        end
    end

endmodule

// File: rtl/fill_dma_addr_count.sv
module fill_dma_addr_count #(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 32,
    parameter int STEP_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [ADDR_W-1:0] cur_o,
    output logic [SIZE_W-1:0] remain_o,
    output logic              last_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] remain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q   <= '0;
            remain_q <= '0;
        end else if (load_i) begin
            addr_q   <= start_i;
            remain_q <= size_i;
        end else if (adv_i) begin
            addr_q   <= addr_q + ADDR_W'(step_i);
            remain_q <= remain_q - SIZE_W'(step_i);
        end
    end

    assign cur_o    = addr_q;
    assign remain_o = remain_q;
    assign last_o   = (remain_q == SIZE_W'(step_i));

    // R11: a grant never consumes more bytes than remain
    assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |-> (remain_q >= SIZE_W'(step_i)));

endmodule

// File: rtl/fill_dma.sv
module fill_dma
    import fill_dma_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 32,
    parameter int NARROW_W = 32,
    localparam int STRB_W  = DATA_W / 8,
    localparam int STEP_W  = $clog2(STRB_W) + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic              err_clr_i,
    input  logic [3:0]        opcode_i,
    input  logic [3:0]        space_i,
    input  logic [1:0]        width_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [DATA_W-1:0] pat_lo_i,
    input  logic [DATA_W-1:0] pat_hi_i,
    output logic              req_o,
    input  logic              gnt_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [STRB_W-1:0] be_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ERR_W-1:0]  err_o
);

    fsm_e state_q, state_d;

    logic [3:0]        op_q;
    logic [3:0]        space_q;
    logic [1:0]        width_q;
    logic [DATA_W-1:0] pat_lo_q;
    logic [DATA_W-1:0] pat_hi_q;
    logic [ERR_W-1:0]  err_q;

    logic              load;
    logic              adv;
    logic              last;
    logic              in_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [SIZE_W-1:0] remain;
    logic [STEP_W-1:0] step;
    logic [ERR_W-1:0]  chk_err;

    // Configuration capture, only when idle
    assign load = (state_q == ST_IDLE) && go_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            op_q     <= '0;
            space_q  <= '0;
            width_q  <= '0;
            pat_lo_q <= '0;
            pat_hi_q <= '0;
        end else if (load) begin
            op_q     <= opcode_i;
            space_q  <= space_i;
            width_q  <= width_i;
            pat_lo_q <= pat_lo_i;
            pat_hi_q <= pat_hi_i;
        end
    end

    fill_dma_addr_count #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .STEP_W (STEP_W)
    ) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .start_i  (dst_addr_i),
        .size_i   (size_i),
        .adv_i    (adv),
        .step_i   (step),
        .cur_o    (cur_addr),
        .remain_o (remain),
        .last_o   (last)
    );

    fill_dma_cfg_check #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .NARROW_W (NARROW_W)
    ) u_check (
        .op_i    (op_q),
        .space_i (space_q),
        .width_i (width_q),
        .dst_i   (cur_addr),
        .size_i  (remain),
        .err_o   (chk_err)
    );

    fill_dma_lane_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lane (
        .active_i (in_write),
        .width_i  (width_q),
        .cur_i    (cur_addr),
        .pat_lo_i (pat_lo_q),
        .pat_hi_i (pat_hi_q),
        .step_o   (step),
        .addr_o   (addr_o),
        .wdata_o  (wdata_o),
        .be_o     (be_o)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_i) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (|chk_err) state_d = ST_IDLE;
                else          state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (gnt_i && last) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_write = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o   = 1'b0;
            ST_CHECK:  in_write = 1'b0;
            ST_WRITE:  in_write = 1'b1;
            ST_FINISH: done_o   = 1'b1;
            default:   busy_o   = 1'b0;
        endcase
    end

    assign req_o = in_write;
    assign adv   = in_write && gnt_i;

    // Sticky error bits
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= '0;
        end else begin
            err_q <= (err_clr_i ? '0 : err_q) |
                     ((state_q == ST_CHECK) ? chk_err : '0);
        end
    end

    assign err_o = err_q;

    // R2: a failing check never produces a request
    assert_no_write_on_error_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CHECK && (|chk_err)) |=> !req_o);

    // R10: enable count matches the width
    assert_be_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> ($countones(be_o) == int'(step)));

    // R11: request holds steady until granted
    assert_hold_until_grant_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !gnt_i) |=> (req_o && $stable(addr_o) && $stable(wdata_o) && $stable(be_o)));

    // R12: done is a single pulse and the engine is idle afterwards
    assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

    // R13: set error bits are kept until cleared
    assert_errors_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|err_o) && !err_clr_i) |=> ((err_o & $past(err_o)) == $past(err_o)));

endmodule

// File: tb/fill_dma_test.sv
module fill_dma_test;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  sp;
        logic [1:0]  w;
        logic [63:0] addr;
        logic [31:0] size;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [3:0]  eerr;
        logic [7:0]  nwr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{4'h4, 4'h7, 2'd2, 64'h1000,              32'd16, 32'hA1B2C3D4, 32'h11223344, 4'h0, 8'd4},
        '{4'h4, 4'h9, 2'd2, 64'h0000_0005_0000_0004, 32'd8, 32'h55667788, 32'h99AABBCC, 4'h0, 8'd2},
        '{4'h4, 4'hA, 2'd0, 64'h2003,              32'd6,  32'h0F1E2D3C, 32'h4B5A6978, 4'h0, 8'd6},
        '{4'h4, 4'h7, 2'd1, 64'h3006,              32'd6,  32'hCAFEF00D, 32'hBEEF1234, 4'h0, 8'd3},
        '{4'h0, 4'h7, 2'd2, 64'h1000,              32'd8,  32'h1,        32'h2,        4'h1, 8'd0},
        '{4'h9, 4'h7, 2'd2, 64'h1000,              32'd8,  32'h1,        32'h2,        4'h1, 8'd0},
        '{4'h4, 4'h5, 2'd2, 64'h1000,              32'd8,  32'h1,        32'h2,        4'h2, 8'd0},
        '{4'h4, 4'h7, 2'd2, 64'h1002,              32'd8,  32'h1,        32'h2,        4'h4, 8'd0},
        '{4'h4, 4'hA, 2'd1, 64'h1001,              32'd8,  32'h1,        32'h2,        4'h4, 8'd0},
        '{4'h4, 4'h7, 2'd2, 64'h1_0000_0000,       32'd8,  32'h1,        32'h2,        4'h4, 8'd0},
        '{4'h4, 4'h7, 2'd2, 64'h1000,              32'd0,  32'h1,        32'h2,        4'h8, 8'd0},
        '{4'h4, 4'h7, 2'd3, 64'h1000,              32'd8,  32'h1,        32'h2,        4'h8, 8'd0},
        '{4'h4, 4'h7, 2'd2, 64'h1000,              32'd6,  32'h1,        32'h2,        4'h8, 8'd0},
        '{4'h4, 4'h7, 2'd2, 64'h4008,              32'd8,  32'h00000003, 32'hDEADBEEF, 4'h0, 8'd2},
        '{4'h5, 4'h0, 2'd2, 64'h1001,              32'd0,  32'h1,        32'h2,        4'hF, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        clr = 1'b0;
    logic [3:0]  op = '0;
    logic [3:0]  sp = '0;
    logic [1:0]  wc = '0;
    logic [63:0] dst = '0;
    logic [31:0] size = '0;
    logic [31:0] plo = '0;
    logic [31:0] phi = '0;
    logic        gnt = 1'b0;
    logic        req;
    logic [63:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        busy;
    logic        done;
    logic [3:0]  err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    bit hold_gnt = 1'b0;
    logic [63:0] exp_addr = '0;
    logic [1:0]  exp_w = '0;
    logic [31:0] exp_lo = '0;
    logic [31:0] exp_hi = '0;

    always #10 clk = ~clk;

    fill_dma uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .go_i       (go),
        .err_clr_i  (clr),
        .opcode_i   (op),
        .space_i    (sp),
        .width_i    (wc),
        .dst_addr_i (dst),
        .size_i     (size),
        .pat_lo_i   (plo),
        .pat_hi_i   (phi),
        .req_o      (req),
        .gnt_i      (gnt),
        .addr_o     (addr),
        .wdata_o    (wdata),
        .be_o       (be),
        .busy_o     (busy),
        .done_o     (done),
        .err_o      (err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Grant driver and write monitor
    always @(negedge clk) begin
        logic [3:0]  ebe;
        logic [31:0] ed;
        int          st;
        cyc++;
        gnt = hold_gnt ? 1'b0 : ((cyc % 3) != 2);
        if (done) done_cnt++;
        if (req && gnt) begin
            st  = (exp_w == 2'd0) ? 1 : ((exp_w == 2'd1) ? 2 : 4);
            ebe = (exp_w == 2'd0) ? 4'b0001 : ((exp_w == 2'd1) ? 4'b0011 : 4'b1111);
            ebe = ebe << exp_addr[1:0];
            ed  = exp_addr[2] ? exp_hi : exp_lo;
            check(addr == {exp_addr[63:2], 2'b00}, "R9 write address", addr, {exp_addr[63:2], 2'b00});
            check(wdata == ed, "R9 pattern half", 64'(wdata), 64'(ed));
            check(be == ebe, "R10 byte enables", 64'(be), 64'(ebe));
            exp_addr = exp_addr + 64'(st);
            wr_cnt++;
        end
    end

    task automatic setup(input vec_t v);
        op = v.op; sp = v.sp; wc = v.w; dst = v.addr; size = v.size;
        plo = v.lo; phi = v.hi;
        exp_addr = v.addr; exp_w = v.w; exp_lo = v.lo; exp_hi = v.hi;
        wr_cnt = 0; done_cnt = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run(input vec_t v);
        setup(v);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        wait_idle();
    endtask

    task automatic clear_errors();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!req && !busy && !done, "R1 control outputs", {61'b0, req, busy, done}, 64'h0);
        check(err == 4'h0 && addr == '0 && wdata == '0 && be == '0, "R1 error and bus", 64'(err), 64'h0);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R11 R12
        for (int i = 0; i < NV; i++) begin
            run(VEC[i]);
            check(err == VEC[i].eerr, "R2/R3/R4/R5/R6/R7 error bits", 64'(err), 64'(VEC[i].eerr));
            check(wr_cnt == int'(VEC[i].nwr), "R11 write count", 64'(wr_cnt), 64'(VEC[i].nwr));
            check(done_cnt == ((VEC[i].eerr == 4'h0) ? 1 : 0), "R12 done pulses",
                  64'(done_cnt), 64'((VEC[i].eerr == 4'h0) ? 1 : 0));
            // R14: bus quiet when idle while pattern inputs are nonzero
            check(!req && addr == '0 && wdata == '0 && be == '0, "R14 idle bus", {addr[31:0], wdata}, 64'h0);
            clear_errors();
            check(err == 4'h0, "R13 clear", 64'(err), 64'h0);
        end

        // R8: request timing after go
        setup(VEC[0]);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check(busy && !req, "R8 check cycle has no request", {62'b0, busy, req}, 64'h2);
        check(addr == '0 && wdata == '0, "R14 bus quiet during check", {addr[31:0], wdata}, 64'h0);
        @(negedge clk);
        check(req == 1'b1, "R8 request in second cycle", 64'(req), 64'h1);
        wait_idle();
        check(wr_cnt == 4, "R8 run completes", 64'(wr_cnt), 64'd4);

        // R13: errors accumulate without clear
        run(VEC[4]);
        run(VEC[6]);
        check(err == 4'h3, "R13 sticky accumulate", 64'(err), 64'h3);
        @(negedge clk);
        check(err == 4'h3, "R13 still held", 64'(err), 64'h3);
        clear_errors();
        check(err == 4'h0, "R13 cleared", 64'(err), 64'h0);

        // R13 + R11: go while busy is ignored, request held under stall
        hold_gnt = 1'b1;
        setup(VEC[0]);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(req && addr == 64'h1000, "R11 request held while stalled", addr, 64'h1000);
        op = 4'h9; dst = 64'h7777; size = 32'd4; plo = 32'h0; phi = 32'h0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        check(req && wdata == 32'hA1B2C3D4, "R13 go ignored while busy", 64'(wdata), 64'hA1B2C3D4);
        hold_gnt = 1'b0;
        wait_idle();
        check(wr_cnt == 4 && err == 4'h0, "R13 run unaffected", 64'(wr_cnt), 64'd4);
        check(done_cnt == 1, "R12 single done", 64'(done_cnt), 64'd1);

        report();
        $finish;
    end

endmodule